// File: doc/BRIEF.md
# Square-Wave Channel Frequency Sweep Unit

This block slides the pitch of a square-wave sound channel up or down over time. It holds an 11-bit timer period. From that period it keeps computing a target period: the period is shifted right by a programmable amount, and the result is either added to the period or subtracted from it. On selected half-frame clocks the target replaces the period. The block also raises a mute output when the period is too short to be useful, or when an upward sweep would leave the 11-bit range.

Software sets the block up through a small write port. The port carries a sweep control byte and the low and high bytes of the period. A write to the period high byte also sends a one-cycle pulse that restarts the phase of the waveform sequencer. The parameter `CH_ID` picks the subtraction variant, so two channel instances sweep downward at slightly different rates.

Top module: `pulse_sweep`

## Requirements
- R1: After reset the period is 0, the control byte is 0, mute_o is 1 (the period is below 8) and phase_rst_o is 0.
- R2: The write select takes the values 0 (control byte), 1 (period bits 7:0 from wr_data_i) and 2 (period bits 10:8 from wr_data_i[2:0]; wr_data_i[7:3] are ignored). Select 3 changes nothing. A written period shows on period_o one cycle after the write.
- R3: phase_rst_o is high for exactly the one cycle after each write with select 2, and low after any other cycle.
- R4: mute_o is 1 whenever the period is below 8.
- R5: Control byte fields: bit 7 enable, bits 6:4 divider period P, bit 3 negate, bits 2:0 shift S. With negate clear, mute_o is 1 when period + (period >> S) exceeds 0x7FF, even while enable is clear. Writing 0x08 never mutes a period of 8 or more.
- R6: With negate set, the target is period − (period >> S) − 1 when CH_ID is 0 and period − (period >> S) when CH_ID is 1. For the same period and S the two instances therefore end up one apart.
- R7: On a half-frame clock, the target is loaded into the period if, and only if, the divider is 0, enable is 1, S is not 0 and mute_o is 0.
- R8: A control write sets a reload flag. On each half-frame clock the divider is loaded with P if it is 0 or the flag is set, and is decremented otherwise. The flag is then cleared. The divider resets to 0, so with P fixed the updates come every P+1 half-frames.
- R9: Without a half-frame clock or a period write the period holds. A muted channel, S = 0 or a clear enable also leaves the period unchanged on a half-frame clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 period low, 2 period high, 3 none |
| wr_data_i | input | 8 | Write data |
| half_frame_i | input | 1 | Half-frame clock enable, one cycle wide |
| period_o | output | 11 | Current timer period |
| mute_o | output | 1 | Channel mute |
| phase_rst_o | output | 1 | Waveform phase restart pulse |

## Verification
The bench builds two copies of the block side by side, one with CH_ID = 0 and one with CH_ID = 1. All other parameters keep their defaults (11-bit period, mute limit 8, 3-bit divider). Both copies get identical writes and half-frame clocks. This puts the one-count difference between the two negate variants in view on the same cycle. The full 11-bit period range is available, so upward sweeps can reach the 0x7FF overflow that mutes a disabled channel.

// File: rtl/pulse_sweep_pkg.sv
package pulse_sweep_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PLO  = 2'd1,
    SEL_PHI  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic       en;
    logic [2:0] div_per;
    logic       neg;
    logic [2:0] shift;
  } sweep_ctrl_t;
endpackage

// File: rtl/sweep_target.sv
module sweep_target #(
  parameter int CH_ID    = 0,
  parameter int PERIOD_W = 11,
  parameter int SHIFT_W  = 3
) (
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                neg_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [PERIOD_W:0]   target_o,
  output logic                ovf_o
);
  logic [PERIOD_W-1:0] delta;
  logic [PERIOD_W:0]   sum_up, sum_dn;

  assign delta  = period_i >> shift_i;
  assign sum_up = {1'b0, period_i} + {1'b0, delta};

  generate
    if (CH_ID == 0) begin : g_ones
      // extra borrow: period - delta - 1
      assign sum_dn = {1'b0, period_i} - {1'b0, delta} - (PERIOD_W+1)'(1);
    end else begin : g_twos
      assign sum_dn = {1'b0, period_i} - {1'b0, delta};
    end
  endgenerate

  assign target_o = neg_i ? sum_dn : sum_up;
  assign ovf_o    = !neg_i && sum_up[PERIOD_W];
endmodule

// File: rtl/sweep_divider.sv
module sweep_divider #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             half_frame_i,
  input  logic [DIV_W-1:0] reload_val_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             reload_q;

  assign tick_o = half_frame_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      if (half_frame_i) begin
        if (cnt_q == '0 || reload_q) cnt_q <= reload_val_i;
        else                         cnt_q <= cnt_q - 1'b1;
      end
      if (ctrl_wr_i)         reload_q <= 1'b1;
      else if (half_frame_i) reload_q <= 1'b0;
    end
  end

  p_reload_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_frame_i && !ctrl_wr_i |=> !reload_q);
  p_reload_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> reload_q);
  p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_frame_i && cnt_q != '0 && !reload_q |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep
  import pulse_sweep_pkg::*;
#(
  parameter int CH_ID    = 0,
  parameter int PERIOD_W = 11,
  parameter int MUTE_MIN = 8,
  parameter int DIV_W    = 3,
  parameter int SHIFT_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [7:0]          wr_data_i,
  input  logic                half_frame_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic                mute_o,
  output logic                phase_rst_o
);
  localparam int HI_W = PERIOD_W - 8;
  localparam logic [PERIOD_W-1:0] MUTE_LIM = PERIOD_W'(MUTE_MIN);

  sweep_ctrl_t         ctrl_q;
  logic [PERIOD_W-1:0] period_q;
  logic                phase_q;
  logic                wr_ctrl, wr_lo, wr_hi;
  logic [PERIOD_W:0]   target;
  logic                ovf, tick, update;
  logic [7-HI_W:0]     unused_hi_bits;

  assign wr_ctrl = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CTRL);
  assign wr_lo   = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_PLO);
  assign wr_hi   = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_PHI);
  assign unused_hi_bits = wr_data_i[7:HI_W];

  sweep_target #(.CH_ID(CH_ID), .PERIOD_W(PERIOD_W), .SHIFT_W(SHIFT_W)) i_target (
    .period_i (period_q),
    .neg_i    (ctrl_q.neg),
    .shift_i  (ctrl_q.shift),
    .target_o (target),
    .ovf_o    (ovf)
  );

  sweep_divider #(.DIV_W(DIV_W)) i_divider (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (wr_ctrl),
    .half_frame_i (half_frame_i),
    .reload_val_i (DIV_W'(ctrl_q.div_per)),
    .tick_o       (tick)
  );

  // mute is evaluated regardless of the enable bit
  assign mute_o = (period_q < MUTE_LIM) || ovf;
  assign update = tick && ctrl_q.en && (ctrl_q.shift != '0) && !mute_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
      phase_q  <= 1'b0;
    end else begin
      phase_q <= wr_hi;
      if (wr_ctrl) ctrl_q <= wr_data_i;
      if (wr_lo)                   period_q[7:0]          <= wr_data_i;
      else if (wr_hi)              period_q[PERIOD_W-1:8] <= wr_data_i[HI_W-1:0];
      else if (update)             period_q               <= target[PERIOD_W-1:0];
    end
  end

  assign period_o    = period_q;
  assign phase_rst_o = phase_q;

  p_phase_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> phase_rst_o);
  p_phase_only_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi |=> !phase_rst_o);
  p_ovf_mutes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.neg && target[PERIOD_W] |-> mute_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_frame_i && !wr_en_i |=> $stable(period_o));
  p_muted_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_frame_i && mute_o && !wr_en_i |=> $stable(period_o));
  p_disabled_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_frame_i && !ctrl_q.en && !wr_en_i |=> $stable(period_o));
endmodule

// File: tb/test_pulse_sweep.sv
module test_pulse_sweep;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        hf = 1'b0;
  logic [10:0] per0, per1;
  logic        mute0, mute1, ph0, ph1;

  int total = 0, bad = 0;

  // bench reference state
  logic [7:0]  m_ctrl;
  logic [2:0]  m_div;
  logic        m_reload;
  logic [10:0] m_per [2];

  always #4 clk = ~clk;

  pulse_sweep #(.CH_ID(0)) i_pulse_sweep (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .half_frame_i(hf),
    .period_o(per0), .mute_o(mute0), .phase_rst_o(ph0));

  pulse_sweep #(.CH_ID(1)) i_pulse_sweep_b (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .half_frame_i(hf),
    .period_o(per1), .mute_o(mute1), .phase_rst_o(ph1));

  function automatic logic [11:0] f_target(int ch, logic [10:0] p, logic [7:0] c);
    logic [11:0] d;
    d = {1'b0, p >> c[2:0]};
    if (c[3]) return (ch == 0) ? ({1'b0, p} - d - 12'd1) : ({1'b0, p} - d);
    return {1'b0, p} + d;
  endfunction

  function automatic logic f_mute(int ch, logic [10:0] p, logic [7:0] c);
    return (p < 11'd8) || (!c[3] && f_target(ch, p, c) > 12'h7FF);
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 8'd0; m_div = 3'd0; m_reload = 1'b0;
    m_per[0] = 11'd0; m_per[1] = 11'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: begin m_ctrl = d; m_reload = 1'b1; end
      2'd1: begin m_per[0][7:0] = d; m_per[1][7:0] = d; end
      2'd2: begin m_per[0][10:8] = d[2:0]; m_per[1][10:8] = d[2:0]; end
      default: ;
    endcase
  endtask

  task automatic half_frame();
    logic tick;
    @(negedge clk);
    hf = 1'b1;
    @(negedge clk);
    hf = 1'b0;
    tick = (m_div == 3'd0);
    for (int c = 0; c < 2; c++)
      if (tick && m_ctrl[7] && m_ctrl[2:0] != 3'd0 && !f_mute(c, m_per[c], m_ctrl))
        m_per[c] = f_target(c, m_per[c], m_ctrl)[10:0];
    if (m_div == 3'd0 || m_reload) m_div = m_ctrl[6:4];
    else m_div = m_div - 3'd1;
    m_reload = 1'b0;
  endtask

  task automatic set_period(logic [10:0] p);
    wr(2'd1, p[7:0]);
    wr(2'd2, {5'd0, p[10:8]});
  endtask

  task automatic cmp_model(string req);
    chk({req, " per0"}, per0, m_per[0]);
    chk({req, " per1"}, per1, m_per[1]);
    chk({req, " mute0"}, mute0, f_mute(0, m_per[0], m_ctrl));
    chk({req, " mute1"}, mute1, f_mute(1, m_per[1], m_ctrl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 period", per0, 0);
    chk("R1 mute", mute0, 1);
    chk("R1 phase", ph0, 0);

    // R2, R3 writes and phase pulse
    wr(2'd1, 8'h00);
    chk("R3 no pulse on low write", ph0, 0);
    wr(2'd2, 8'h04);
    chk("R2 period hi", per0, 11'h400);
    chk("R3 pulse ch0", ph0, 1);
    chk("R3 pulse ch1", ph1, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", ph0, 0);
    wr(2'd2, 8'hF9);
    chk("R2 upper data ignored", per0, 11'h100);
    wr(2'd3, 8'h55);
    chk("R2 select 3 ignored", per0, 11'h100);
    chk("R3 no pulse on select 3", ph0, 0);

    // R4 low period mute
    set_period(11'd7);
    chk("R4 mute at 7", mute0, 1);
    set_period(11'd8);
    chk("R4 no mute at 8", mute0, 0);

    // R5 overflow mute while disabled, 0x08 clears it
    set_period(11'h7F0);
    wr(2'd0, 8'h01);
    chk("R5 overflow mute disabled ch0", mute0, 1);
    chk("R5 overflow mute disabled ch1", mute1, 1);
    wr(2'd0, 8'h08);
    chk("R5 0x08 unmuted ch0", mute0, 0);
    chk("R5 0x08 unmuted ch1", mute1, 0);

    // R6, R7 negate carry difference
    do_reset();
    set_period(11'h100);
    wr(2'd0, 8'h89);
    half_frame();
    chk("R6 ch0 ones complement", per0, 11'h07F);
    chk("R6 ch1 twos complement", per1, 11'h080);
    chk("R6 difference one", int'(per1) - int'(per0), 1);
    chk("R7 update fired", (per0 != 11'h100) ? 1 : 0, 1);

    // R8 divider period 2
    do_reset();
    set_period(11'h100);
    wr(2'd0, 8'hA1);
    half_frame();
    chk("R8 first update", per0, 11'h180);
    half_frame();
    chk("R8 hold count 1", per0, 11'h180);
    half_frame();
    chk("R8 hold count 0", per0, 11'h180);
    half_frame();
    chk("R8 update after P+1", per0, 11'h240);

    // R9 no update cases
    do_reset();
    set_period(11'h100);
    wr(2'd0, 8'h80);
    half_frame();
    chk("R9 shift zero holds", per0, 11'h100);
    wr(2'd0, 8'h01);
    half_frame();
    chk("R9 disabled holds", per0, 11'h100);
    set_period(11'd7);
    wr(2'd0, 8'h81);
    half_frame();
    chk("R9 muted holds", per0, 11'd7);
    repeat (5) @(negedge clk);
    chk("R9 idle holds", per1, 11'd7);

    // random mix, R2 R5 R6 R7 R8 R9 against model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2)      wr(2'd0, 8'($urandom));
      else if (op < 3) wr(2'd1, 8'($urandom));
      else if (op < 4) wr(2'd2, 8'($urandom));
      else if (op < 5) wr(2'd3, 8'($urandom));
      else             half_frame();
      cmp_model("R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule